// File: doc/BRIEF.md
# Opcode-Driven Command/Response Framer

This block sits between a byte stream from a host and a command handler inside a power-management controller. The first byte of each frame is an opcode. An internal table indexed by that opcode says how many argument bytes follow and how many result bytes go back. Either figure may be fixed, or it may be "counted": a counted argument field starts with a byte that gives its size, and a counted result starts with a byte the framer emits that gives the result's size. The argument bytes are collected into a command buffer. The framer then sends a start pulse to the handler with the opcode and the number of bytes stored. The handler reads the arguments through a read port, fills a result buffer through a write port, and ends its turn with a done pulse. The framer then streams the result out.

Both byte streams use valid/ready. An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the framer is waiting for an opcode, a count byte or an argument byte. An output byte is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The sink may stall for any number of cycles. The handler must not write the result buffer while a result is streaming out.

Top module: `cmd_framer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the framer to waiting for an opcode: `in_ready`=1, `out_valid`=0, `hnd_start`=0, `err`=0.
- R2: The length table gives these entries. 0x38: 0 argument bytes, 4 result bytes. 0x30: 4 argument bytes, no result. 0x70: 1 argument byte, no result. 0x78: 0 argument bytes, counted result. 0xEA: 0 argument bytes, 1 result byte. 0x7E and 0x7F: 4 argument bytes, 1 result byte. Every other opcode has a counted argument field, and has a counted result when opcode bit 3 is 1 or no result when it is 0.
- R3: For an opcode with 0 fixed argument bytes, `hnd_start` is high in the cycle after the opcode is taken, with `hnd_len`=0. `in_ready` stays low from then until the frame ends.
- R4: For a fixed argument count N>0, `hnd_start` rises in the cycle after the N-th argument byte is taken. Command buffer address i (through `hnd_rd_addr`/`hnd_rd_data`) then holds argument byte i, and `hnd_len`=N.
- R5: For a counted argument field, the byte after the opcode is the count C. Exactly C further bytes are taken. C=0 dispatches right after the count byte.
- R6: `hnd_start` is high for exactly one cycle per frame. A `hnd_done` pulse that arrives in the same cycle as `hnd_start`, or at any time the framer is not waiting on the handler, has no effect.
- R7: For a fixed result count R>0, the framer emits result buffer bytes 0..R-1 after `hnd_done`. `hnd_rsp_len` is ignored.
- R8: For a counted result, the first output byte is the count L taken from `hnd_rsp_len` at `hnd_done`. Result buffer bytes 0..L-1 follow. L=0 emits only the count byte.
- R9: A result count of 0 returns the framer to taking input in the cycle after `hnd_done`, and no output byte is produced.
- R10: A count byte C>128 sets `err`. All C bytes are still taken. Only the first 128 are stored, and `hnd_len`=128.
- R11: A counted result with `hnd_rsp_len`>128 sets `err` and is sent as a count byte of 128 followed by 128 bytes.
- R12: While `out_valid`=1, `in_ready`=0. While `out_valid`=1 and `out_ready`=0, `out_data` is held stable into the next cycle.
- R13: `err` stays set through any later frames until a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Framer can take an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| hnd_start | output | 1 | One-cycle dispatch pulse to the handler |
| hnd_opcode | output | 8 | Opcode of the current frame |
| hnd_len | output | 8 | Number of argument bytes stored |
| hnd_rd_addr | input | 7 | Command buffer read address |
| hnd_rd_data | output | 8 | Command buffer read data (combinational) |
| hnd_done | input | 1 | Handler finished; result is in the result buffer |
| hnd_rsp_len | input | 8 | Result length for opcodes with a counted result |
| hnd_wr_en | input | 1 | Result buffer write enable |
| hnd_wr_addr | input | 7 | Result buffer write address |
| hnd_wr_data | input | 8 | Result buffer write data |
| err | output | 1 | Sticky overflow flag |

## Verification
The bench runs a handler model and keeps a queue of the bytes the output must carry. It compares each byte consumed against that queue, with stalls on the sink side. Several corner cases are targeted:
- A dispatch that does not happen in the cycle right after the opcode would show up for zero-argument opcodes.
- An early done pulse is sent in the start cycle. A framer that accepted it would emit a result before the handler had written one.
- A counted result of zero must still emit its count byte, while a fixed zero result must emit nothing.
- An oversize count must set the error flag. The stored length is capped, yet every byte of the long frame must still be taken, so a framer that dropped bytes from the stream would misread the next opcode.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam int BYTE_W = 8;

  // Length descriptor for one opcode: a fixed count, or a count carried in the stream
  typedef struct packed {
    logic              cmd_var;
    logic [BYTE_W-1:0] cmd_len;
    logic              rsp_var;
    logic [BYTE_W-1:0] rsp_len;
  } len_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an opcode
    ST_LEN,    // waiting for the argument count byte
    ST_DATA,   // collecting argument bytes
    ST_CALL,   // start pulse to the handler
    ST_WAIT,   // waiting for handler completion
    ST_RHDR,   // emitting the result count byte
    ST_RDATA   // emitting result bytes
  } fr_state_e;

  function automatic len_entry_t make_entry(input logic cv, input int cl,
                                            input logic rv, input int rl);
    len_entry_t e;
    e.cmd_var = cv;
    e.cmd_len = BYTE_W'(cl);
    e.rsp_var = rv;
    e.rsp_len = BYTE_W'(rl);
    return e;
  endfunction

  // Opcode table: a few fixed entries, everything else follows a bit-3 rule
  function automatic len_entry_t lookup_len(input logic [BYTE_W-1:0] op);
    len_entry_t e;
    case (op)
      8'h38:        e = make_entry(1'b0, 0, 1'b0, 4);
      8'h30:        e = make_entry(1'b0, 4, 1'b0, 0);
      8'h70:        e = make_entry(1'b0, 1, 1'b0, 0);
      8'h78:        e = make_entry(1'b0, 0, 1'b1, 0);
      8'hEA:        e = make_entry(1'b0, 0, 1'b0, 1);
      8'h7E, 8'h7F: e = make_entry(1'b0, 4, 1'b0, 1);
      default:      e = make_entry(1'b1, 0, op[3], 0);
    endcase
    return e;
  endfunction

endpackage

// File: rtl/fr_len_table.sv
module fr_len_table
  import framer_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output len_entry_t        entry
);
  always_comb entry = lookup_len(opcode);
endmodule

// File: rtl/fr_byte_buf.sv
module fr_byte_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import framer_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              hnd_start,
  output logic [BYTE_W-1:0] hnd_opcode,
  output logic [BYTE_W-1:0] hnd_len,
  input  logic [ADDR_W-1:0] hnd_rd_addr,
  output logic [BYTE_W-1:0] hnd_rd_data,
  input  logic              hnd_done,
  input  logic [BYTE_W-1:0] hnd_rsp_len,
  input  logic              hnd_wr_en,
  input  logic [ADDR_W-1:0] hnd_wr_addr,
  input  logic [BYTE_W-1:0] hnd_wr_data,
  output logic              err
);
  localparam int FILL_W = ADDR_W + 1;
  localparam logic [FILL_W-1:0] DEPTH_F = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] ONE_F   = FILL_W'(1);
  localparam logic [BYTE_W-1:0] DEPTH_B = BYTE_W'(DEPTH);
  localparam logic [BYTE_W-1:0] ONE_B   = BYTE_W'(1);

  fr_state_e         state_q;
  logic [BYTE_W-1:0] opcode_q;
  logic              rsp_var_q;
  logic [BYTE_W-1:0] rsp_fix_q;
  logic [BYTE_W-1:0] remain_q;
  logic [FILL_W-1:0] fill_q;
  logic [BYTE_W-1:0] rlen_q;
  logic [FILL_W-1:0] rptr_q;
  logic              err_q;

  len_entry_t        tbl;
  logic              in_fire;
  logic              out_fire;
  logic              cmd_we;
  logic [BYTE_W-1:0] rsp_rd_data;
  logic [BYTE_W-1:0] var_len_clamped;
  logic              var_len_over;

  fr_len_table u_tbl (
    .opcode (in_data),
    .entry  (tbl)
  );

  fr_byte_buf #(.DATA_W(BYTE_W), .DEPTH(DEPTH)) u_cmd_buf (
    .clk     (clk),
    .wr_en   (cmd_we),
    .wr_addr (fill_q[ADDR_W-1:0]),
    .wr_data (in_data),
    .rd_addr (hnd_rd_addr),
    .rd_data (hnd_rd_data)
  );

  fr_byte_buf #(.DATA_W(BYTE_W), .DEPTH(DEPTH)) u_rsp_buf (
    .clk     (clk),
    .wr_en   (hnd_wr_en),
    .wr_addr (hnd_wr_addr),
    .wr_data (hnd_wr_data),
    .rd_addr (rptr_q[ADDR_W-1:0]),
    .rd_data (rsp_rd_data)
  );

  assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_LEN) || (state_q == ST_DATA);
  assign in_fire   = in_valid && in_ready;
  assign out_valid = (state_q == ST_RHDR) || (state_q == ST_RDATA);
  assign out_fire  = out_valid && out_ready;
  assign out_data  = (state_q == ST_RHDR) ? rlen_q : rsp_rd_data;
  assign cmd_we    = in_fire && (state_q == ST_DATA) && (fill_q < DEPTH_F);

  assign hnd_start  = (state_q == ST_CALL);
  assign hnd_opcode = opcode_q;
  assign hnd_len    = BYTE_W'(fill_q);
  assign err        = err_q;

  assign var_len_over    = hnd_rsp_len > DEPTH_B;
  assign var_len_clamped = var_len_over ? DEPTH_B : hnd_rsp_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      opcode_q  <= '0;
      rsp_var_q <= 1'b0;
      rsp_fix_q <= '0;
      remain_q  <= '0;
      fill_q    <= '0;
      rlen_q    <= '0;
      rptr_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (in_fire) begin
            opcode_q  <= in_data;
            rsp_var_q <= tbl.rsp_var;
            rsp_fix_q <= (tbl.rsp_len > DEPTH_B) ? DEPTH_B : tbl.rsp_len;
            fill_q    <= '0;
            if (tbl.cmd_var) begin
              state_q <= ST_LEN;
            end else if (tbl.cmd_len == '0) begin
              state_q <= ST_CALL;
            end else begin
              remain_q <= tbl.cmd_len;
              state_q  <= ST_DATA;
            end
          end
        end
        ST_LEN: begin
          if (in_fire) begin
            if (in_data > DEPTH_B) err_q <= 1'b1;
            if (in_data == '0) begin
              state_q <= ST_CALL;
            end else begin
              remain_q <= in_data;
              state_q  <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (in_fire) begin
            if (fill_q < DEPTH_F) fill_q <= fill_q + ONE_F;
            remain_q <= remain_q - ONE_B;
            if (remain_q == ONE_B) state_q <= ST_CALL;
          end
        end
        ST_CALL: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (hnd_done) begin
            rptr_q <= '0;
            if (rsp_var_q) begin
              rlen_q  <= var_len_clamped;
              if (var_len_over) err_q <= 1'b1;
              state_q <= ST_RHDR;
            end else if (rsp_fix_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              rlen_q  <= rsp_fix_q;
              state_q <= ST_RDATA;
            end
          end
        end
        ST_RHDR: begin
          if (out_fire) state_q <= (rlen_q == '0) ? ST_IDLE : ST_RDATA;
        end
        ST_RDATA: begin
          if (out_fire) begin
            rptr_q <= rptr_q + ONE_F;
            if (BYTE_W'(rptr_q) + ONE_B == rlen_q) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fr_checker.sv
module fr_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       hnd_start,
  input logic       err
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid && !hnd_start && !err)); // R1

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    hnd_start |-> (!in_ready && !out_valid)); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    hnd_start |=> !hnd_start); // R6

  AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R12

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R13
endmodule

bind cmd_framer fr_checker u_fr_checker (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .hnd_start (hnd_start),
  .err       (err)
);

// File: tb/test_cmd_framer.sv
`timescale 1ns/1ps
module test_cmd_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       hnd_start;
  logic [7:0] hnd_opcode;
  logic [7:0] hnd_len;
  logic [6:0] hnd_rd_addr = '0;
  logic [7:0] hnd_rd_data;
  logic       hnd_done = 1'b0;
  logic [7:0] hnd_rsp_len = '0;
  logic       hnd_wr_en = 1'b0;
  logic [6:0] hnd_wr_addr = '0;
  logic [7:0] hnd_wr_data = '0;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit exp_err = 0;
  int fires = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data = '0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  cmd_framer i_cmd_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .hnd_start(hnd_start), .hnd_opcode(hnd_opcode), .hnd_len(hnd_len),
    .hnd_rd_addr(hnd_rd_addr), .hnd_rd_data(hnd_rd_data), .hnd_done(hnd_done),
    .hnd_rsp_len(hnd_rsp_len), .hnd_wr_en(hnd_wr_en), .hnd_wr_addr(hnd_wr_addr),
    .hnd_wr_data(hnd_wr_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Length rules written from the requirement list (R2)
  function automatic void ref_len(input logic [7:0] op, output bit cv, output int cl,
                                  output bit rv, output int rl);
    cv = 0; cl = 0; rv = 0; rl = 0;
    if (op == 8'h38) rl = 4;
    else if (op == 8'h30) cl = 4;
    else if (op == 8'h70) cl = 1;
    else if (op == 8'h78) rv = 1;
    else if (op == 8'hEA) rl = 1;
    else if (op == 8'h7E || op == 8'h7F) begin cl = 4; rl = 1; end
    else begin cv = 1; rv = op[3]; end
  endfunction

  function automatic logic [7:0] arg_byte(input logic [7:0] op, input int i);
    return 8'((op * 3) + i * 7);
  endfunction

  function automatic logic [7:0] res_byte(input logic [7:0] op, input int i);
    return 8'((op ^ 8'h5A) + i * 13);
  endfunction

  // Per-cycle monitor, sampled after the bench has driven its inputs
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R12", "held output byte", out_data, prev_data);
      if (out_valid && in_ready)
        chk(0, "R12", "in_ready while out_valid", 1, 0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else prev_stall = 0;
  end

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] op, input int cnt_byte, input int given,
                           input int nwrite, input bit early_done, input bit stall,
                           input string req);
    bit cv, rv;
    int cl, rl, nargs, stored, n, cyc, fires0;
    ref_len(op, cv, cl, rv, rl);
    nargs = cv ? cnt_byte : cl;
    stored = (nargs > 128) ? 128 : nargs;
    if (cv && cnt_byte > 128) exp_err = 1;
    put_byte(op);
    if (cv) put_byte(8'(cnt_byte));
    for (int i = 0; i < nargs; i++) put_byte(arg_byte(op, i));
    #1;
    chk(hnd_start == 1'b1, req, "start pulse after last input byte", hnd_start, 1);
    chk(in_ready == 1'b0, "R3", "in_ready during dispatch", in_ready, 0);
    chk(hnd_opcode == op, req, "opcode to handler", hnd_opcode, op);
    chk(hnd_len == 8'(stored), req, "stored argument count", hnd_len, stored);
    for (int i = 0; i < stored; i++) begin
      hnd_rd_addr = 7'(i);
      #0.001;
      if (hnd_rd_data !== arg_byte(op, i))
        chk(0, req, "argument byte in command buffer", hnd_rd_data, arg_byte(op, i));
    end
    if (stored > 0) chk(1, req, "argument bytes compared", 0, 0);
    fires0 = fires;
    if (early_done) begin
      hnd_done = 1'b1; hnd_rsp_len = 8'd5;
      @(negedge clk); hnd_done = 1'b0;
      #1;
      chk(!out_valid && !in_ready, "R6", "done during start cycle ignored", out_valid, 0);
    end
    for (int i = 0; i < nwrite; i++) begin
      @(negedge clk);
      hnd_wr_en = 1'b1; hnd_wr_addr = 7'(i); hnd_wr_data = res_byte(op, i);
    end
    @(negedge clk);
    hnd_wr_en = 1'b0;
    hnd_done = 1'b1; hnd_rsp_len = 8'(given);
    expq.delete();
    if (rv) begin
      n = (given > 128) ? 128 : given;
      if (given > 128) exp_err = 1;
      expq.push_back(8'(n));
    end else n = rl;
    for (int i = 0; i < n; i++) expq.push_back(res_byte(op, i));
    @(negedge clk);
    hnd_done = 1'b0;
    cyc = 0;
    while (expq.size() > 0 && cyc < 2000) begin
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        fires++;
        chk(out_data == expq[0], req, "output byte", out_data, expq[0]);
        void'(expq.pop_front());
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(expq.size() == 0, req, "all result bytes emitted", expq.size(), 0);
    #1;
    chk(!out_valid && in_ready, req, "back to taking input", out_valid, 0);
    if (n == 0 && !rv) chk(fires == fires0, "R9", "no output bytes", fires - fires0, 0);
    chk(err == exp_err, "R13", "error flag", err, exp_err);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid && !hnd_start && !err, "R1", "state during reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    run_frame(8'h38, 0, 9, 4, 0, 0, "R7");   // R3 zero args, R7 fixed result ignores length
    run_frame(8'h30, 0, 0, 0, 0, 0, "R4");   // R4 fixed args, R9 no result
    run_frame(8'h70, 0, 0, 0, 1, 0, "R6");   // R6 early done ignored
    run_frame(8'hEA, 0, 0, 1, 0, 1, "R2");   // R2 one result byte with stalls
    run_frame(8'h7E, 0, 0, 1, 0, 0, "R4");
    run_frame(8'h78, 0, 6, 6, 0, 1, "R8");   // R8 counted result with stalls
    run_frame(8'h78, 0, 0, 0, 0, 0, "R8");   // R8 count byte only
    run_frame(8'h12, 3, 0, 0, 0, 0, "R5");   // R5 counted args, bit3=0 no result
    run_frame(8'h1A, 0, 2, 2, 0, 0, "R5");   // R5 zero count, bit3=1 counted result
    run_frame(8'h12, 130, 0, 0, 0, 0, "R10"); // R10 oversize argument count
    run_frame(8'h78, 0, 200, 128, 0, 0, "R11"); // R11 oversize result count
    rst = 1'b1;
    @(negedge clk); #1;
    exp_err = 0;
    rst = 1'b0;
    chk(err == 1'b0 && in_ready, "R13", "reset clears sticky error", err, 0);
    @(negedge clk);
    run_frame(8'h7F, 0, 0, 1, 0, 1, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule